// File: doc/BRIEF.md
# Four-Channel Round-Robin Burst DMA Engine

This block moves data between memory locations on behalf of four independent channels. Each channel holds a source address, a destination address, a byte count and a control word, all reached over a simple register bus. Software starts a channel by raising its go bit. From then on, a periodic burst tick supplied from outside hands the memory master port to one eligible channel for one burst. In the intended system that tick runs at one forty-eighth of a 33 MHz bus clock. The channel is picked by a rotating pointer that starts just past the channel served last.

A burst performs up to 32 transfers. Each transfer is a read cycle followed by a write cycle. A 32-bit word moves while four or more bytes remain; otherwise a single byte moves. When the burst ends, the working source, destination and low 16 count bits go back into the channel registers, so a long job resumes on a later tick. When the count reaches zero, the channel flags a completion interrupt unless its mask bit is set. An external "next available" level is then sampled: low ends the channel, high keeps it active.

The engine walks four states. ST_IDLE waits for a tick. ST_READ drives a read. ST_WRITE drives the matching write. ST_WBACK stores the working copy back into the channel registers. The transitions are:
- tick accepted: ST_IDLE to ST_READ, or ST_IDLE to ST_WBACK when the count is already zero.
- read done: ST_READ to ST_WRITE.
- more to move: ST_WRITE to ST_READ.
- burst over: ST_WRITE to ST_WBACK.
- stored: ST_WBACK to ST_IDLE.

Top module: `dma4_rr_engine`

## Requirements
- R1: After reset, every channel register reads zero, irq_state is zero, and neither memory strobe is asserted.
- R2: Register address bits [3:2] select the channel and bits [1:0] select the field (0 source, 1 destination, 2 count, 3 control). A channel becomes active only when a control write takes bit 12 from 0 to 1 while the channel is inactive. Control bit 14 reads back the channel's active flag.
- R3: Control bit 14 cannot be written; writes to it never change what it reads.
- R4: On a tick, channels are examined in the order last+1, last+2, last+3, last+4 (mod 4). The first channel that is both active and has bit 12 set is served, and it becomes the new "last". The "last" pointer resets to channel 0, so channel 1 is examined first.
- R5: A burst ends after 32 transfers or when the count reaches zero, whichever comes first. The rest of the job waits for a later tick.
- R6: While the count is 4 or more, a transfer moves a 32-bit word with mem_word high and the count drops by 4. Otherwise it moves one byte in data bits [7:0] with mem_word low and the count drops by 1.
- R7: Control bits [1:0] set the source address mode and bits [3:2] the destination address mode: 0 increments, 1 decrements, 2 or 3 holds. The step is 4 for a word transfer and 1 for a byte transfer.
- R8: After every burst, the source, the destination and count bits [15:0] are written back. Count bits [31:16] keep their value.
- R9: At count zero, irq_state[channel] is set unless control bit 10 is set. An irq_state bit stays set until the same bit of irq_clr is pulsed.
- R10: next_avail is sampled at completion. Low clears the channel's active flag; high leaves it active.
- R11: A tick that arrives while no channel is eligible, or while a burst is in progress, is ignored.
- R12: Every write cycle follows a read cycle in the previous clock. The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel [3:2] and field [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| burst_tick | input | 1 | Scheduler pulse granting one burst |
| next_avail | input | 1 | Keep channel active at completion |
| irq_clr | input | 4 | Write-one-to-clear of irq_state |
| irq_state | output | 4 | Completion interrupt per channel |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_word | output | 1 | 1 for 32-bit transfer, 0 for byte |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read cycle |

## Verification
The assertions assume three things about the inputs. Memory returns read data in the same cycle as mem_rd. Software leaves a channel's registers alone while that channel's burst is in flight. irq_clr is only pulsed, never held. The stimulus meets these by modelling memory as a combinational byte array. It also waits a fixed 80 cycles after each tick, longer than the longest burst (66 cycles), before touching any register, and it pulses irq_clr for exactly one clock.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WBACK = 2'd3
    } eng_state_t;

    // control word bit positions
    localparam int CTL_SMODE_LSB = 0;
    localparam int CTL_DMODE_LSB = 2;
    localparam int CTL_NOIRQ     = 10;
    localparam int CTL_GO        = 12;
    localparam int CTL_BUSY      = 14;

    // register field select
    localparam logic [1:0] FLD_SRC = 2'd0;
    localparam logic [1:0] FLD_DST = 2'd1;
    localparam logic [1:0] FLD_CNT = 2'd2;
    localparam logic [1:0] FLD_CTL = 2'd3;

    // address step modes
    localparam logic [1:0] AM_UP   = 2'd0;
    localparam logic [1:0] AM_DOWN = 2'd1;

endpackage

// File: rtl/dma4_chan_regs.sv
module dma4_chan_regs
    import dma4_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_field,
    input  logic [AW-1:0] wr_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_src,
    input  logic [AW-1:0] wb_dst,
    input  logic [CW-1:0] wb_cnt,
    input  logic          drop_active,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] cnt_q,
    output logic [AW-1:0] ctl_q,
    output logic          active_q
);

    localparam logic [AW-1:0] BUSY_MASK = AW'(1) << CTL_BUSY;

    logic [AW-1:0] ctl_store;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            ctl_store <= '0;
            active_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_field)
                    FLD_SRC: src_q <= wr_data;
                    FLD_DST: dst_q <= wr_data;
                    FLD_CNT: cnt_q <= wr_data;
                    FLD_CTL: begin
                        ctl_store <= wr_data & ~BUSY_MASK;
                        if (!ctl_store[CTL_GO] && wr_data[CTL_GO] && !active_q)
                            active_q <= 1'b1;
                    end
                endcase
            end
            if (wb_en) begin
                src_q          <= wb_src;
                dst_q          <= wb_dst;
                cnt_q[CW-1:0]  <= wb_cnt;
            end
            if (drop_active)
                active_q <= 1'b0;
        end
    end

    assign ctl_q = ctl_store | (active_q ? BUSY_MASK : '0);

endmodule

// File: rtl/dma4_rr_pick.sv
module dma4_rr_pick #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] req,
    input  logic [CHW-1:0] last,
    output logic           found,
    output logic [CHW-1:0] pick
);

    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int i = 1; i <= NCH; i++) begin
            int j;
            j = (int'(last) + i) % NCH;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = CHW'(j);
            end
        end
    end

endmodule

// File: rtl/dma4_burst_fsm.sv
module dma4_burst_fsm
    import dma4_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int BURST = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    next_avail,
    input  logic [NCH-1:0]          elig,
    input  logic [NCH-1:0][AW-1:0]  ch_src,
    input  logic [NCH-1:0][AW-1:0]  ch_dst,
    input  logic [NCH-1:0][CW-1:0]  ch_cnt,
    input  logic [NCH-1:0][1:0]     ch_smode,
    input  logic [NCH-1:0][1:0]     ch_dmode,
    input  logic [NCH-1:0]          ch_noirq,
    input  logic [31:0]             mem_rdata,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic                    mem_word,
    output logic [AW-1:0]           mem_addr,
    output logic [31:0]             mem_wdata,
    output logic [NCH-1:0]          wb_en,
    output logic [AW-1:0]           wb_src,
    output logic [AW-1:0]           wb_dst,
    output logic [CW-1:0]           wb_cnt,
    output logic [NCH-1:0]          drop,
    output logic [NCH-1:0]          irq_set,
    output logic                    idle,
    output logic                    wb_phase
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int XW  = $clog2(BURST + 1);

    eng_state_t    state, state_nx;
    logic [CHW-1:0] cur_ch, last_ch, pick;
    logic          found;
    logic [AW-1:0] w_src, w_dst;
    logic [CW-1:0] w_cnt, cnt_after;
    logic [31:0]   w_data;
    logic [1:0]    w_smode, w_dmode;
    logic [XW-1:0] xfer_n;
    logic          is_word;
    logic          burst_over;

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a,
                                              input logic [1:0] mode,
                                              input logic word);
        logic [AW-1:0] s;
        s = word ? AW'(4) : AW'(1);
        if (mode == AM_UP)        return a + s;
        else if (mode == AM_DOWN) return a - s;
        else                      return a;
    endfunction

    dma4_rr_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req   (elig),
        .last  (last_ch),
        .found (found),
        .pick  (pick)
    );

    assign is_word    = (w_cnt >= CW'(4));
    assign cnt_after  = w_cnt - (is_word ? CW'(4) : CW'(1));
    assign burst_over = (cnt_after == '0) || (xfer_n == XW'(BURST - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick && found)
                          state_nx = (ch_cnt[pick] == '0) ? ST_WBACK : ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = burst_over ? ST_WBACK : ST_READ;
            ST_WBACK: state_nx = ST_IDLE;
        endcase
    end

    // working copy of the served channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch  <= '0;
            last_ch <= '0;
            w_src   <= '0;
            w_dst   <= '0;
            w_cnt   <= '0;
            w_data  <= '0;
            w_smode <= '0;
            w_dmode <= '0;
            xfer_n  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (tick && found) begin
                    cur_ch  <= pick;
                    last_ch <= pick;
                    w_src   <= ch_src[pick];
                    w_dst   <= ch_dst[pick];
                    w_cnt   <= ch_cnt[pick];
                    w_smode <= ch_smode[pick];
                    w_dmode <= ch_dmode[pick];
                    xfer_n  <= '0;
                end
                ST_READ:  w_data <= mem_rdata;
                ST_WRITE: begin
                    w_src  <= stepped(w_src, w_smode, is_word);
                    w_dst  <= stepped(w_dst, w_dmode, is_word);
                    w_cnt  <= cnt_after;
                    xfer_n <= xfer_n + XW'(1);
                end
                ST_WBACK: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = (state == ST_READ);
        mem_wr    = (state == ST_WRITE);
        mem_word  = is_word;
        mem_addr  = (state == ST_READ) ? w_src : w_dst;
        mem_wdata = is_word ? w_data : {24'b0, w_data[7:0]};
        idle      = (state == ST_IDLE);
        wb_phase  = (state == ST_WBACK);
        wb_src    = w_src;
        wb_dst    = w_dst;
        wb_cnt    = w_cnt;
        wb_en     = '0;
        drop      = '0;
        irq_set   = '0;
        if (state == ST_WBACK) begin
            wb_en[cur_ch] = 1'b1;
            if (w_cnt == '0) begin
                irq_set[cur_ch] = !ch_noirq[cur_ch];
                drop[cur_ch]    = !next_avail;
            end
        end
    end

endmodule

// File: rtl/dma4_rr_engine.sv
module dma4_rr_engine
    import dma4_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int BURST = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [$clog2(NCH)+1:0]        reg_addr,
    input  logic [AW-1:0]                 reg_wdata,
    output logic [AW-1:0]                 reg_rdata,
    input  logic                          burst_tick,
    input  logic                          next_avail,
    input  logic [NCH-1:0]                irq_clr,
    output logic [NCH-1:0]                irq_state,
    output logic                          mem_rd,
    output logic                          mem_wr,
    output logic                          mem_word,
    output logic [AW-1:0]                 mem_addr,
    output logic [31:0]                   mem_wdata,
    input  logic [31:0]                   mem_rdata
);

    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0][AW-1:0] ch_src, ch_dst, ch_cnt_full, ch_ctl;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0][1:0]    ch_smode, ch_dmode;
    logic [NCH-1:0]         ch_noirq, act, elig;
    logic [NCH-1:0]         wb_en, drop, irq_set;
    logic [AW-1:0]          wb_src, wb_dst;
    logic [CW-1:0]          wb_cnt;
    logic                   eng_idle, wb_any;
    logic [CHW-1:0]         rd_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma4_chan_regs #(.AW(AW), .CW(CW)) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_we && (reg_addr[CHW+1:2] == CHW'(c))),
            .wr_field    (reg_addr[1:0]),
            .wr_data     (reg_wdata),
            .wb_en       (wb_en[c]),
            .wb_src      (wb_src),
            .wb_dst      (wb_dst),
            .wb_cnt      (wb_cnt),
            .drop_active (drop[c]),
            .src_q       (ch_src[c]),
            .dst_q       (ch_dst[c]),
            .cnt_q       (ch_cnt_full[c]),
            .ctl_q       (ch_ctl[c]),
            .active_q    (act[c])
        );
        assign ch_cnt[c]   = ch_cnt_full[c][CW-1:0];
        assign ch_smode[c] = ch_ctl[c][CTL_SMODE_LSB +: 2];
        assign ch_dmode[c] = ch_ctl[c][CTL_DMODE_LSB +: 2];
        assign ch_noirq[c] = ch_ctl[c][CTL_NOIRQ];
        assign elig[c]     = act[c] && ch_ctl[c][CTL_GO];
    end

    dma4_burst_fsm #(.NCH(NCH), .AW(AW), .CW(CW), .BURST(BURST)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (burst_tick),
        .next_avail (next_avail),
        .elig       (elig),
        .ch_src     (ch_src),
        .ch_dst     (ch_dst),
        .ch_cnt     (ch_cnt),
        .ch_smode   (ch_smode),
        .ch_dmode   (ch_dmode),
        .ch_noirq   (ch_noirq),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_word   (mem_word),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wb_en      (wb_en),
        .wb_src     (wb_src),
        .wb_dst     (wb_dst),
        .wb_cnt     (wb_cnt),
        .drop       (drop),
        .irq_set    (irq_set),
        .idle       (eng_idle),
        .wb_phase   (wb_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_state <= '0;
        else        irq_state <= (irq_state & ~irq_clr) | irq_set;
    end

    assign rd_ch = reg_addr[CHW+1:2];

    always_comb begin
        unique case (reg_addr[1:0])
            FLD_SRC: reg_rdata = ch_src[rd_ch];
            FLD_DST: reg_rdata = ch_dst[rd_ch];
            FLD_CNT: reg_rdata = ch_cnt_full[rd_ch];
            FLD_CTL: reg_rdata = ch_ctl[rd_ch];
        endcase
    end

endmodule

// File: rtl/dma4_rr_checker.sv
module dma4_rr_checker #(
    parameter int NCH   = 4,
    parameter int BURST = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           burst_tick,
    input logic           eng_idle,
    input logic           wb_any,
    input logic [NCH-1:0] elig,
    input logic [NCH-1:0] irq_state,
    input logic [NCH-1:0] irq_clr
);

    localparam int XW = $clog2(BURST + 2);

    logic [XW-1:0] writes_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)      writes_seen <= '0;
        else if (wb_any) writes_seen <= '0;
        else if (mem_wr) writes_seen <= writes_seen + XW'(1);
    end

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_write_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    assert_burst_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        writes_seen <= XW'(BURST));

    assert_idle_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_tick && eng_idle && (elig == '0)) |=> (!mem_rd && !mem_wr));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_state & ~$past(irq_state)) != '0) |-> $past(wb_any));

    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_state & $past(irq_state)) != '0) |-> ($past(irq_clr) != '0));

endmodule

bind dma4_rr_engine dma4_rr_checker #(.NCH(NCH), .BURST(BURST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .burst_tick (burst_tick),
    .eng_idle   (eng_idle),
    .wb_any     (wb_any),
    .elig       (elig),
    .irq_state  (irq_state),
    .irq_clr    (irq_clr)
);

// File: tb/dma4_rr_engine_tb.sv
module dma4_rr_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        burst_tick = 1'b0;
    logic        next_avail = 1'b0;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq_state;
    logic        mem_rd, mem_wr, mem_word;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int n_words = 0;
    int n_bytes = 0;
    int n_reads = 0;
    bit finished = 0;

    logic [7:0] mem [1024];

    always #4 clk = ~clk;

    dma4_rr_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_tick(burst_tick),
        .next_avail(next_avail), .irq_clr(irq_clr), .irq_state(irq_state),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [9:0] ma0, ma1, ma2, ma3;
    assign ma0 = mem_addr[9:0];
    assign ma1 = ma0 + 10'd1;
    assign ma2 = ma0 + 10'd2;
    assign ma3 = ma0 + 10'd3;
    assign mem_rdata = {mem[ma3], mem[ma2], mem[ma1], mem[ma0]};

    // byte memory model with fill pattern a ^ 0x5A during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
        end else begin
            if (mem_rd) n_reads = n_reads + 1;
            if (mem_wr) begin
                mem[ma0] = mem_wdata[7:0];
                if (mem_word) begin
                    mem[ma1] = mem_wdata[15:8];
                    mem[ma2] = mem_wdata[23:16];
                    mem[ma3] = mem_wdata[31:24];
                    n_words = n_words + 1;
                end else begin
                    n_bytes = n_bytes + 1;
                end
            end
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(ch * 4 + fld); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output logic [31:0] d);
        reg_addr = 4'(ch * 4 + fld);
        #1 d = reg_rdata;
    endtask

    task automatic tick_wait();
        @(negedge clk); burst_tick = 1'b1;
        @(negedge clk); burst_tick = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic clear_irq(input logic [3:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = '0;
    endtask

    task automatic start(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] c, input logic [31:0] ctl);
        wr(ch, 3, 32'h0);
        wr(ch, 0, s);
        wr(ch, 1, d);
        wr(ch, 2, c);
        wr(ch, 3, ctl);
    endtask

    // vector table: ch0 single-burst jobs with differing modes and sizes
    localparam int NV = 5;
    localparam logic [31:0] V_SRC  [NV] = '{32'h000, 32'h010, 32'h020, 32'h03C, 32'h045};
    localparam logic [31:0] V_DST  [NV] = '{32'h080, 32'h090, 32'h0A0, 32'h0B0, 32'h0C5};
    localparam logic [31:0] V_CNT  [NV] = '{32'd10, 32'd7, 32'd3, 32'd8, 32'd2};
    localparam logic [31:0] V_CTL  [NV] = '{32'h1000, 32'h1000, 32'h1008, 32'h1001, 32'h1005};
    localparam logic [31:0] V_ESRC [NV] = '{32'h00A, 32'h017, 32'h023, 32'h034, 32'h043};
    localparam logic [31:0] V_EDST [NV] = '{32'h08A, 32'h097, 32'h0A0, 32'h0B8, 32'h0C3};
    localparam int          V_EW   [NV] = '{2, 1, 0, 2, 0};
    localparam int          V_EB   [NV] = '{2, 3, 3, 0, 2};
    localparam int          V_CADR [NV] = '{'h089, 'h096, 'h0A0, 'h0B4, 'h0C4};
    localparam logic [7:0]  V_CVAL [NV] = '{8'h53, 8'h4C, 8'h78, 8'h62, 8'h1E};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w0, b0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a / 4, a % 4, d);
            chk("R1 register after reset", d, 32'h0);
        end
        chk("R1 irq_state after reset", 32'(irq_state), 32'h0);
        chk("R1 strobes after reset", {30'b0, mem_rd, mem_wr}, 32'h0);

        // table walk: R6 R7 R8 R9 R12
        for (int v = 0; v < NV; v++) begin
            start(0, V_SRC[v], V_DST[v], V_CNT[v], V_CTL[v]);
            w0 = n_words; b0 = n_bytes;
            tick_wait();
            rd(0, 0, d); chk($sformatf("R7 vec%0d source", v), d, V_ESRC[v]);
            rd(0, 1, d); chk($sformatf("R7 vec%0d destination", v), d, V_EDST[v]);
            rd(0, 2, d); chk($sformatf("R8 vec%0d count", v), d, 32'h0);
            chk($sformatf("R6 vec%0d word moves", v), 32'(n_words - w0), 32'(V_EW[v]));
            chk($sformatf("R6 vec%0d byte moves", v), 32'(n_bytes - b0), 32'(V_EB[v]));
            chk($sformatf("R12 vec%0d data byte", v), 32'(mem[V_CADR[v]]), 32'(V_CVAL[v]));
            chk($sformatf("R9 vec%0d irq", v), 32'(irq_state), 32'h1);
            rd(0, 3, d); chk($sformatf("R10 vec%0d inactive", v), d[14], 1'b0);
            clear_irq(4'h1);
            chk($sformatf("R9 vec%0d irq cleared", v), 32'(irq_state), 32'h0);
        end

        // R5 burst limit: 200 bytes = 50 word moves, 32 in first burst
        start(0, 32'h000, 32'h200, 32'd200, 32'h1000);
        tick_wait();
        rd(0, 2, d); chk("R5 count after first burst", d, 32'd72);
        rd(0, 0, d); chk("R8 source after first burst", d, 32'h080);
        rd(0, 3, d); chk("R2 still active mid job", d, 32'h5000);
        chk("R9 no irq mid job", 32'(irq_state), 32'h0);
        chk("R12 burst data", 32'(mem[10'h27F]), 32'(pat('h7F)));
        tick_wait();
        rd(0, 2, d); chk("R5 count after second burst", d, 32'h0);
        rd(0, 1, d); chk("R8 destination at end", d, 32'h2C8);
        chk("R9 irq at end", 32'(irq_state), 32'h1);
        clear_irq(4'h1);

        // R8 upper count bits kept
        start(0, 32'h000, 32'h200, 32'hABCD_0008, 32'h1000);
        tick_wait();
        rd(0, 2, d); chk("R8 upper count bits", d, 32'hABCD_0000);
        clear_irq(4'h1);

        // R9 masked completion
        start(0, 32'h000, 32'h200, 32'd4, 32'h1400);
        tick_wait();
        chk("R9 masked irq", 32'(irq_state), 32'h0);
        rd(0, 2, d); chk("R9 masked job done", d, 32'h0);

        // R2 no restart without 0->1 edge
        wr(0, 2, 32'd8);
        wr(0, 3, 32'h1400);
        tick_wait();
        rd(0, 2, d); chk("R2 no start on 1->1", d, 32'd8);
        rd(0, 3, d); chk("R2 control readback", d, 32'h1400);

        // R3 busy bit not writable
        wr(2, 3, 32'h4000);
        rd(2, 3, d); chk("R3 busy write ignored", d, 32'h0);

        // R10 next descriptor available keeps channel active
        start(0, 32'h000, 32'h200, 32'd4, 32'h1400);
        next_avail = 1'b1;
        tick_wait();
        rd(0, 3, d); chk("R10 kept active", d, 32'h5400);
        next_avail = 1'b0;
        r0 = n_reads;
        tick_wait();
        rd(0, 3, d); chk("R10 dropped active", d, 32'h1400);
        chk("R10 zero-count burst no reads", 32'(n_reads - r0), 32'h0);

        // R11 tick with nothing eligible
        r0 = n_reads;
        tick_wait();
        chk("R11 idle tick ignored", 32'(n_reads - r0), 32'h0);

        // R4 round robin: ch0, ch1, ch2 active, last=0 after reset
        start(0, 32'h000, 32'h200, 32'd200, 32'h1400);
        start(1, 32'h000, 32'h300, 32'd200, 32'h1400);
        start(2, 32'h000, 32'h100, 32'd200, 32'h1400);
        tick_wait();
        rd(1, 2, d); chk("R4 first grant ch1", d, 32'd72);
        rd(0, 2, d); chk("R4 ch0 waiting", d, 32'd200);
        tick_wait();
        rd(2, 2, d); chk("R4 second grant ch2", d, 32'd72);
        tick_wait();
        rd(0, 2, d); chk("R4 third grant wraps to ch0", d, 32'd72);
        tick_wait();
        rd(1, 2, d); chk("R4 fourth grant ch1 done", d, 32'h0);
        tick_wait();
        tick_wait();
        rd(2, 2, d); chk("R4 ch2 done", d, 32'h0);
        rd(0, 2, d); chk("R4 ch0 done", d, 32'h0);

        // R4 active but go bit cleared is skipped
        start(3, 32'h000, 32'h200, 32'd8, 32'h1400);
        wr(3, 3, 32'h0400);
        tick_wait();
        rd(3, 2, d); chk("R4 disabled channel skipped", d, 32'd8);
        rd(3, 3, d); chk("R3 busy kept after write", d, 32'h4400);
        wr(3, 3, 32'h1400);
        tick_wait();
        rd(3, 2, d); chk("R4 re-enabled channel served", d, 32'h0);
        rd(3, 3, d); chk("R10 ch3 inactive", d, 32'h1400);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule